// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides a selectable source clock-enable stream down to a square-wave baud clock. A 16-bit time constant, loaded one byte at a time through a small configuration port, sets the divide ratio. Each half period of the baud clock lasts the time constant plus two source ticks, so a full period spans `2 x (TC + 2)` source ticks. A second output marks every sixteenth rising edge of the baud clock with a one-cycle pulse. This is the bit rate for a serial engine that oversamples by sixteen. For example, a 4.9152 MHz source with TC = 14 gives a 153.6 kHz baud clock and 9600 bit-rate pulses per second.

Software enables or freezes the generator and picks one of two source tick inputs. Each time the down counter expires and reloads, the generator sets a sticky zero-count status flag. When the zero-count interrupt enable is set, that flag also drives an interrupt request. A new time constant is picked up at the next reload, so a running half period is never cut short.

Top module: `baud_rate_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `baud_clk_o`, `bit_tick_o`, `zc_status_o` and `zc_irq_o` are all 0.
- R2: The time constant is written as bytes: select 0 loads bits 7:0 and select 1 loads bits 15:8. While the generator is enabled, `baud_clk_o` toggles once every TC + 2 selected source ticks.
- R3: The control register is at select 2. Its bit 0 is the enable. While the enable is 0, source ticks are ignored: `baud_clk_o` holds its level and the count holds its value. After the enable is set again, counting resumes from the held value.
- R4: Bit 1 of the control register picks the source: 0 selects `src_tick_a` and 1 selects `src_tick_b`. Ticks on the input that is not selected have no effect.
- R5: A time constant written during a half period does not change that half period. It takes effect from the next reload.
- R6: Each reload sets `zc_status_o`, and the flag stays set until a write to select 4 clears it. If a reload and a clear happen in the same cycle, the flag stays set.
- R7: The interrupt control register is at select 3. Its bit 1 is the zero-count interrupt enable. `zc_irq_o` is 1 exactly when `zc_status_o` is 1 and that enable is 1.
- R8: `bit_tick_o` is a one-cycle pulse. It rises with every sixteenth rising edge of `baud_clk_o`, counted from reset.
- R9: After reset the count is zero. The first selected tick after the generator is enabled therefore reloads the counter and drives `baud_clk_o` high.
- R10: Outputs are registered. A tick sampled at a clock edge shows up on `baud_clk_o`, `bit_tick_o` and `zc_status_o` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select (0 TC low, 1 TC high, 2 control, 3 interrupt control, 4 status clear) |
| cfg_wdata | input | 8 | Configuration write data |
| src_tick_a | input | 1 | Source clock-enable A |
| src_tick_b | input | 1 | Source clock-enable B |
| baud_clk_o | output | 1 | Square-wave baud clock |
| bit_tick_o | output | 1 | One-cycle pulse on every 16th baud rising edge |
| zc_status_o | output | 1 | Sticky zero-count status |
| zc_irq_o | output | 1 | Zero-count interrupt request |

## Verification
The divide ratio is measured by counting source ticks between baud edges for several time constants. TC = 14 gives the 9600-baud case. A value of 0x0102 shows that the high byte is used and that the "+2" is added in the right place rather than "+1". Freezing in mid-count and then resuming shows that the count is held rather than reset. A time constant rewritten in mid-count separates reload-time loading from immediate loading. Ticks on the source that is not selected, and a clear that coincides with a reload, check the isolation between sources and which event wins. A fast TC = 0 run checks the spacing of the bit-rate pulses over two full groups of sixteen.

// File: rtl/brg_pkg.sv
// Package: shared constants for the baud rate generator.
// Assumes: time constant is a whole number of bytes; configuration
// selects are laid out TC bytes first, then control, interrupt, clear.
package brg_pkg;
    localparam int BYTE_W       = 8;
    localparam int CTRL_EN_BIT  = 0;  // generator run enable
    localparam int CTRL_SRC_BIT = 1;  // 0: source A, 1: source B
    localparam int IRQ_ZC_BIT   = 1;  // zero-count interrupt enable

    // Select offsets that follow the time-constant byte lanes
    localparam int OFS_CTRL = 0;
    localparam int OFS_IRQ  = 1;
    localparam int OFS_CLR  = 2;
endpackage

// File: rtl/brg_cfg_regs.sv
// Module: configuration registers and sticky zero-count flag.
// Assumes: TC_W is a multiple of 8; one write per cycle; a zero event
// outranks a clear arriving in the same cycle.
module brg_cfg_regs
    import brg_pkg::*;
#(
    parameter int TC_W  = 16,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              zero_evt,
    output logic [TC_W-1:0]   tc_o,
    output logic              en_o,
    output logic              src_sel_o,
    output logic              zc_ie_o,
    output logic              zc_flag_o
);
    localparam int TC_BYTES = TC_W / BYTE_W;
    localparam int SEL_CTRL = TC_BYTES + OFS_CTRL;
    localparam int SEL_IRQ  = TC_BYTES + OFS_IRQ;
    localparam int SEL_CLR  = TC_BYTES + OFS_CLR;

    // One byte lane of the time constant per generate iteration
    for (genvar lane = 0; lane < TC_BYTES; lane++) begin : g_tc_lane
        // Load this byte of the time constant on its select
        always_ff @(posedge clk) begin
            if (!rst_n)
                tc_o[lane*BYTE_W +: BYTE_W] <= '0;
            else if (we && sel == SEL_W'(lane))
                tc_o[lane*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // Control register: enable and source select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o      <= 1'b0;
            src_sel_o <= 1'b0;
        end else if (we && sel == SEL_W'(SEL_CTRL)) begin
            en_o      <= wdata[CTRL_EN_BIT];
            src_sel_o <= wdata[CTRL_SRC_BIT];
        end
    end

    // Interrupt control register: zero-count interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            zc_ie_o <= 1'b0;
        else if (we && sel == SEL_W'(SEL_IRQ))
            zc_ie_o <= wdata[IRQ_ZC_BIT];
    end

    // Sticky zero-count flag; set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            zc_flag_o <= 1'b0;
        else if (zero_evt)
            zc_flag_o <= 1'b1;
        else if (we && sel == SEL_W'(SEL_CLR))
            zc_flag_o <= 1'b0;
    end
endmodule

// File: rtl/brg_half_counter.sv
// Module: down counter that times one half period of the baud clock.
// Assumes: tick is already qualified by enable and source select. The
// counter reloads TC+1, so a half period spans TC+2 ticks; TC is
// sampled only at reload.
module brg_half_counter #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [TC_W-1:0] tc,
    output logic            zero_evt_o,
    output logic            rise_evt_o,
    output logic            baud_o
);
    localparam int CNT_W = TC_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload_val;
    logic             at_zero;

    // Reload value and expiry detection
    always_comb begin
        reload_val = {1'b0, tc} + CNT_W'(1);
        at_zero    = (cnt == '0);
        zero_evt_o = tick && at_zero;
        rise_evt_o = zero_evt_o && !baud_o;
    end

    // Count down on each tick; reload and toggle at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            baud_o <= 1'b0;
        end else if (tick) begin
            if (at_zero) begin
                cnt    <= reload_val;
                baud_o <= ~baud_o;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/brg_rate_div.sv
// Module: divides baud rising edges by the oversampling factor.
// Assumes: OVS >= 2; rise_evt is a single-cycle strobe.
module brg_rate_div #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_evt,
    output logic bit_tick_o
);
    localparam int SUB_W = $clog2(OVS);

    logic [SUB_W-1:0] sub;

    // Count rising edges; pulse on the last one of each group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub        <= '0;
            bit_tick_o <= 1'b0;
        end else if (rise_evt) begin
            if (sub == SUB_W'(OVS - 1)) begin
                sub        <= '0;
                bit_tick_o <= 1'b1;
            end else begin
                sub        <= sub + SUB_W'(1);
                bit_tick_o <= 1'b0;
            end
        end else begin
            bit_tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/baud_rate_gen.sv
// Module: programmable baud rate generator top level.
// Assumes: source tick inputs are synchronous single-cycle enables;
// configuration writes arrive on the system clock.
module baud_rate_gen
    import brg_pkg::*;
#(
    parameter int TC_W  = 16,
    parameter int SEL_W = 3,
    parameter int OVS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              src_tick_a,
    input  logic              src_tick_b,
    output logic              baud_clk_o,
    output logic              bit_tick_o,
    output logic              zc_status_o,
    output logic              zc_irq_o
);
    logic [TC_W-1:0] tc;
    logic            en;
    logic            src_sel;
    logic            zc_ie;
    logic            src_live;
    logic            zero_evt;
    logic            rise_evt;

    brg_cfg_regs #(.TC_W(TC_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .zero_evt  (zero_evt),
        .tc_o      (tc),
        .en_o      (en),
        .src_sel_o (src_sel),
        .zc_ie_o   (zc_ie),
        .zc_flag_o (zc_status_o)
    );

    // Qualify the chosen source tick with the run enable
    always_comb begin
        src_live = en && (src_sel ? src_tick_b : src_tick_a);
    end

    brg_half_counter #(.TC_W(TC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (src_live),
        .tc         (tc),
        .zero_evt_o (zero_evt),
        .rise_evt_o (rise_evt),
        .baud_o     (baud_clk_o)
    );

    brg_rate_div #(.OVS(OVS)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_evt   (rise_evt),
        .bit_tick_o (bit_tick_o)
    );

    // Interrupt request from status gated by its enable
    always_comb begin
        zc_irq_o = zc_status_o && zc_ie;
    end
endmodule

// File: rtl/baud_rate_gen_chk.sv
// Module: property checker bound to the baud rate generator.
module baud_rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic en,
    input logic src_live,
    input logic zero_evt,
    input logic zc_ie,
    input logic baud_clk_o,
    input logic bit_tick_o,
    input logic zc_status_o,
    input logic zc_irq_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!baud_clk_o && !bit_tick_o && !zc_status_o && !zc_irq_o));

    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(baud_clk_o));

    // R4
    idle_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_live |=> $stable(baud_clk_o));

    // R6
    zc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> zc_status_o);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && zc_ie && !cfg_we) |=> zc_irq_o);

    // R7
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zc_irq_o |-> zc_status_o);

    // R8
    bit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> $rose(baud_clk_o));

    // R8
    bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> !bit_tick_o);
endmodule

bind baud_rate_gen baud_rate_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .en          (en),
    .src_live    (src_live),
    .zero_evt    (zero_evt),
    .zc_ie       (zc_ie),
    .baud_clk_o  (baud_clk_o),
    .bit_tick_o  (bit_tick_o),
    .zc_status_o (zc_status_o),
    .zc_irq_o    (zc_irq_o)
);

// File: tb/test_baud_rate_gen.sv
module test_baud_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       src_tick_a = 1'b0;
    logic       src_tick_b = 1'b0;
    logic       baud_clk_o, bit_tick_o, zc_status_o, zc_irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    baud_rate_gen i_baud_rate_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .src_tick_a(src_tick_a), .src_tick_b(src_tick_b),
        .baud_clk_o(baud_clk_o), .bit_tick_o(bit_tick_o),
        .zc_status_o(zc_status_o), .zc_irq_o(zc_irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; src_tick_a = 1'b0; src_tick_b = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_tc(input logic [15:0] tc);
        cfg_write(3'd0, tc[7:0]);
        cfg_write(3'd1, tc[15:8]);
    endtask

    task automatic pulse(input bit use_b);
        @(negedge clk);
        if (use_b) src_tick_b = 1'b1; else src_tick_a = 1'b1;
        @(negedge clk);
        src_tick_a = 1'b0; src_tick_b = 1'b0;
    endtask

    task automatic ticks_to_toggle(input bit use_b, input int limit, output int n);
        logic start;
        start = baud_clk_o;
        n = 0;
        while (baud_clk_o == start && n < limit) begin
            pulse(use_b);
            n++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(!baud_clk_o && !bit_tick_o && !zc_status_o && !zc_irq_o, "R1 outputs after reset",
              {baud_clk_o, bit_tick_o, zc_status_o, zc_irq_o}, 0);
    endtask

    task automatic t_period(input logic [15:0] tc);
        int n;
        do_reset();
        set_tc(tc);
        cfg_write(3'd2, 8'h01);
        pulse(1'b0);
        check(baud_clk_o == 1'b1, "R9 first tick raises baud", baud_clk_o, 1);
        check(zc_status_o == 1'b1, "R10 status right after tick edge", zc_status_o, 1);
        ticks_to_toggle(1'b0, 70000, n);
        check(n == int'(tc) + 2, "R2 high half period", n, int'(tc) + 2);
        ticks_to_toggle(1'b0, 70000, n);
        check(n == int'(tc) + 2, "R2 low half period", n, int'(tc) + 2);
    endtask

    task automatic t_freeze();
        logic lvl;
        int n;
        do_reset();
        set_tc(16'd5);
        cfg_write(3'd2, 8'h01);
        pulse(1'b0);
        repeat (3) pulse(1'b0);
        cfg_write(3'd2, 8'h00);
        lvl = baud_clk_o;
        repeat (20) begin pulse(1'b0); pulse(1'b1); end
        check(baud_clk_o == lvl, "R3 baud holds while disabled", baud_clk_o, lvl);
        cfg_write(3'd2, 8'h01);
        ticks_to_toggle(1'b0, 100, n);
        check(n == 4, "R3 count resumes from held value", n, 4);
    endtask

    task automatic t_source();
        int n;
        do_reset();
        set_tc(16'd1);
        cfg_write(3'd2, 8'h03);
        repeat (10) pulse(1'b0);
        check(baud_clk_o == 1'b0, "R4 unselected source A ignored", baud_clk_o, 0);
        pulse(1'b1);
        check(baud_clk_o == 1'b1, "R4 source B drives counter", baud_clk_o, 1);
        ticks_to_toggle(1'b1, 100, n);
        check(n == 3, "R4 period on source B", n, 3);
    endtask

    task automatic t_newtc();
        int n;
        do_reset();
        set_tc(16'd4);
        cfg_write(3'd2, 8'h01);
        pulse(1'b0);
        repeat (2) pulse(1'b0);
        cfg_write(3'd0, 8'd10);
        ticks_to_toggle(1'b0, 100, n);
        check(n == 4, "R5 running half period unchanged", n, 4);
        ticks_to_toggle(1'b0, 100, n);
        check(n == 12, "R5 new TC after reload", n, 12);
    endtask

    task automatic t_flag();
        do_reset();
        set_tc(16'd2);
        cfg_write(3'd2, 8'h01);
        pulse(1'b0);
        check(zc_status_o == 1'b1, "R6 reload sets status", zc_status_o, 1);
        check(zc_irq_o == 1'b0, "R7 irq masked when disabled", zc_irq_o, 0);
        cfg_write(3'd3, 8'h02);
        check(zc_irq_o == 1'b1, "R7 irq follows enable", zc_irq_o, 1);
        cfg_write(3'd4, 8'h00);
        check(zc_status_o == 1'b0 && zc_irq_o == 1'b0, "R6 clear drops status",
              {zc_status_o, zc_irq_o}, 0);
        repeat (3) pulse(1'b0);
        check(zc_status_o == 1'b0, "R6 no set before reload", zc_status_o, 0);
        @(negedge clk);
        src_tick_a = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 8'h00;
        @(negedge clk);
        src_tick_a = 1'b0; cfg_we = 1'b0;
        check(zc_status_o == 1'b1, "R6 set wins over clear", zc_status_o, 1);
        check(baud_clk_o == 1'b0, "R2 toggle on coincident reload", baud_clk_o, 0);
    endtask

    task automatic t_bittick();
        int first_seen;
        int second_seen;
        int count_seen;
        do_reset();
        set_tc(16'd0);
        cfg_write(3'd2, 8'h01);
        first_seen = 0; second_seen = 0; count_seen = 0;
        for (int i = 1; i <= 130; i++) begin
            pulse(1'b0);
            if (bit_tick_o) begin
                count_seen++;
                if (first_seen == 0) first_seen = i;
                else if (second_seen == 0) second_seen = i;
                @(negedge clk);
                check(bit_tick_o == 1'b0, "R8 pulse lasts one cycle", bit_tick_o, 0);
            end
        end
        check(first_seen == 61, "R8 first bit tick on 16th rise", first_seen, 61);
        check(second_seen == 125, "R8 second bit tick on 32nd rise", second_seen, 125);
        check(count_seen == 2, "R8 bit tick count", count_seen, 2);
    endtask

    initial begin
        t_reset();
        t_period(16'd14);
        t_period(16'h0102);
        t_period(16'd0);
        t_freeze();
        t_source();
        t_newtc();
        t_flag();
        t_bittick();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule